// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block sits between an internal single-word request port and an external asynchronous static RAM that is 16 bits wide with separately strobed lower and upper bytes. A requester raises a valid signal with a direction flag, a word address, write data and a 2-bit byte-enable. The controller latches the request and plays out the chip-select, output-enable, write-enable and byte-strobe sequence on the memory pins. It then returns a one-clock ready pulse, together with the read data when the request was a read.

Every phase length is a whole number of clocks. Each is computed at elaboration from a nanosecond budget and the clock period parameter, rounded up, and never less than one clock. The controller drives the shared data bus only during writes. It keeps the bus released whenever the memory may be driving it, and delays a write that follows a read until the memory's release time has passed. Between transfers every strobe is inactive, so the memory drops into its automatic standby.

Top module: `asram_ctrl`

## Requirements
- R1: After reset, and in every clock with no transfer in progress, `mem_ce_n`=1, `mem_oe_n`=1, `mem_we_n`=1, `mem_lb_n`=1, `mem_ub_n`=1, `mem_dq_oe`=0, `req_ready`=0, and `mem_ce2`=0 when the second enable is present.
- R2: Each phase length in clocks is max(1, ceil(ns / CLK_NS)). The read-access phase takes the largest of the cycle-time, address-access and output-enable budgets. The write pulse takes the largest of the pulse-width, data-setup and address-valid budgets.
- R3: A read selects the memory (`mem_ce_n`=0, `mem_ce2`=1, `mem_we_n`=1) with output enable high for exactly one clock. It then holds `mem_oe_n`=0 for exactly N_RD clocks. `mem_dq_oe` stays 0 whenever `mem_oe_n`=0.
- R4: Read data is sampled in the last output-enable clock and presented on `rsp_rdata` while `req_ready` is high. A lane whose enable bit is 0 reads as zero (bit 0 is bits 7:0, bit 1 is bits 15:8).
- R5: A write selects the memory with data driven for N_AS clocks. It then holds `mem_we_n`=0 for exactly N_WP clocks, followed by N_WH hold clocks with select, address and data unchanged. `mem_oe_n` stays 1 throughout, and address and data do not change while `mem_we_n` is low.
- R6: While the memory is selected, `mem_lb_n` equals the inverse of enable bit 0 and `mem_ub_n` equals the inverse of enable bit 1. A write changes only the lanes whose strobe is low, so an enable of 0 leaves the word unchanged.
- R7: When a write follows a read, at least N_TA+1 clocks separate the clock in which `mem_oe_n` returns high from the clock in which `mem_dq_oe` goes high, with N_TA = max(1, ceil(T_HZ_NS / CLK_NS)).
- R8: A request is accepted in the first idle clock with `req_valid`=1. `req_ready` is a single-clock pulse. Counted in clock edges from presentation to ready, latency from idle is 2+N_RD for a read and N_AS+N_WP+N_WH+1 for a write. It is one more when the request is presented in the ready clock of the previous transfer, and a further N_TA-1 more for a write that directly follows a read.
- R9: Address, data, byte-enable and direction are captured at acceptance. Changing the request inputs during a transfer does not alter the pins or the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request present, held until ready |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Lane enables, bit 0 = bits 7:0 |
| req_ready | output | 1 | One-clock completion pulse |
| rsp_rdata | output | 16 | Read data, disabled lanes zero |
| mem_addr | output | ADDR_W | Memory word address |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_ce2 | output | 1 | Second chip enable, active high |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_lb_n | output | 1 | Lower byte strobe, active low |
| mem_ub_n | output | 1 | Upper byte strobe, active low |
| mem_dq_o | output | 16 | Data toward the memory |
| mem_dq_oe | output | 1 | Enable of the data pad drivers |
| mem_dq_i | input | 16 | Data from the memory pads |

## Verification
The hardest case to reach from the ports is a write whose request is already pending at the moment a read completes, because only then does the turnaround counter actually hold the write back. The bench therefore runs interleaved read-then-write pairs back to back, presenting each request in the ready clock of the previous one. It measures the delay from output-enable release to driver enable at the pins and compares it with the computed turnaround. The same sweep rotates every byte-enable pattern over all addresses of a small memory model, so masked writes and masked reads meet each other in every combination.

// File: rtl/asram_pkg.sv
// Shared types and elaboration-time helpers for the asynchronous SRAM controller.
// Assumes a 16-bit memory split into two byte lanes.
package asram_pkg;

    localparam int DATA_W = 16;
    localparam int LANES  = DATA_W / 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RSEL,
        ST_RACC,
        ST_WSET,
        ST_WPUL,
        ST_WHLD,
        ST_DONE
    } state_e;

    // Internal, active-high view of the memory control pins.
    typedef struct packed {
        logic sel;
        logic oe;
        logic we;
        logic drive;
        logic done;
    } ctl_t;

    // Nanoseconds to whole clocks, rounded up, never below one.
    function automatic int ns_to_clk(int ns, int clk_ns);
        int c;
        c = (ns + clk_ns - 1) / clk_ns;
        if (c < 1) c = 1;
        return c;
    endfunction

    function automatic int max3(int a, int b, int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    // Pin pattern held while the controller sits in a given state.
    function automatic ctl_t ctl_of(state_e s);
        ctl_t c;
        c = '0;
        case (s)
            ST_RSEL: c.sel = 1'b1;
            ST_RACC: begin c.sel = 1'b1; c.oe = 1'b1; end
            ST_WSET: begin c.sel = 1'b1; c.drive = 1'b1; end
            ST_WPUL: begin c.sel = 1'b1; c.drive = 1'b1; c.we = 1'b1; end
            ST_WHLD: begin c.sel = 1'b1; c.drive = 1'b1; end
            ST_DONE: c.done = 1'b1;
            default: c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/asram_phase_timer.sv
// Down-counter that measures the length of the current controller phase.
// Assumes load is pulsed in the first clock of a phase with its length (>= 1);
// last is high in the final clock of that phase.
module asram_phase_timer #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] len,
    output logic             last
);

    logic [CNT_W-1:0] cnt_q;

    // Reload on phase entry, otherwise count toward zero and stay there.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt_q <= '0;
        else if (load)       cnt_q <= len - 1'b1;
        else if (cnt_q != 0) cnt_q <= cnt_q - 1'b1;
    end

    assign last = (cnt_q == '0);

endmodule

// File: rtl/asram_lane_map.sv
// Byte-lane mapping: turns lane enables into active-low strobes and zeroes
// the read data of lanes that were not requested. Purely combinational.
module asram_lane_map
    import asram_pkg::*;
(
    input  logic              active,
    input  logic [LANES-1:0]  be,
    input  logic [DATA_W-1:0] rd_in,
    output logic [LANES-1:0]  strobe_n,
    output logic [DATA_W-1:0] rd_masked
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign strobe_n[g]        = ~(active & be[g]);
        assign rd_masked[g*8 +: 8] = be[g] ? rd_in[g*8 +: 8] : 8'h00;
    end

endmodule

// File: rtl/asram_ctrl.sv
// Single-word controller for an external asynchronous 16-bit SRAM.
// Accepts a latched request, plays out select/enable/strobe phases whose
// lengths are derived from nanosecond budgets, and pulses ready at the end.
// Assumes the requester holds req_valid until it sees req_ready, and that
// the pad ring builds the tri-state bus from mem_dq_o / mem_dq_oe / mem_dq_i.
module asram_ctrl
    import asram_pkg::*;
#(
    parameter int ADDR_W  = 19,
    parameter bit HAS_CE2 = 1'b1,
    parameter int CLK_NS  = 10,
    parameter int T_RC_NS = 55,
    parameter int T_AA_NS = 55,
    parameter int T_OE_NS = 30,
    parameter int T_AS_NS = 0,
    parameter int T_WP_NS = 45,
    parameter int T_AW_NS = 45,
    parameter int T_DW_NS = 30,
    parameter int T_DH_NS = 0,
    parameter int T_HZ_NS = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [15:0]       req_wdata,
    input  logic [1:0]        req_be,
    output logic              req_ready,
    output logic [15:0]       rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_ce2,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic              mem_lb_n,
    output logic              mem_ub_n,
    output logic [15:0]       mem_dq_o,
    output logic              mem_dq_oe,
    input  logic [15:0]       mem_dq_i
);

    localparam int N_AS    = ns_to_clk(T_AS_NS, CLK_NS);
    localparam int N_WP    = max3(ns_to_clk(T_WP_NS, CLK_NS),
                                  ns_to_clk(T_DW_NS, CLK_NS),
                                  ns_to_clk(T_AW_NS, CLK_NS));
    localparam int N_WH    = ns_to_clk(T_DH_NS, CLK_NS);
    localparam int N_RD    = max3(ns_to_clk(T_RC_NS, CLK_NS),
                                  ns_to_clk(T_AA_NS, CLK_NS),
                                  ns_to_clk(T_OE_NS, CLK_NS));
    localparam int N_TA    = ns_to_clk(T_HZ_NS, CLK_NS);
    localparam int LEN_MAX = max3(N_AS, N_WP, max3(N_WH, N_RD, 1));
    localparam int CNT_W   = $clog2(LEN_MAX + 1);
    localparam int TA_W    = $clog2(N_TA + 1);

    state_e              state_q, state_nxt;
    ctl_t                ctl_q;
    logic                phase_last;
    logic                phase_load;
    logic [CNT_W-1:0]    phase_len;
    logic [TA_W-1:0]     ta_q;
    logic                accept;
    logic                rd_end;
    logic [ADDR_W-1:0]   addr_q;
    logic [15:0]         wdata_q;
    logic [1:0]          be_q;
    logic                write_q;
    logic [15:0]         rdata_q;
    logic [LANES-1:0]    strobe_n;
    logic [DATA_W-1:0]   rd_masked;

    assign accept = (state_q == ST_IDLE) && req_valid && (!req_write || ta_q == '0);
    assign rd_end = (state_q == ST_RACC) && phase_last;

    // Next-state selection for the transfer sequence.
    always_comb begin
        state_nxt = state_q;
        case (state_q)
            ST_IDLE: if (accept) state_nxt = req_write ? ST_WSET : ST_RSEL;
            ST_RSEL: if (phase_last) state_nxt = ST_RACC;
            ST_RACC: if (phase_last) state_nxt = ST_DONE;
            ST_WSET: if (phase_last) state_nxt = ST_WPUL;
            ST_WPUL: if (phase_last) state_nxt = ST_WHLD;
            ST_WHLD: if (phase_last) state_nxt = ST_DONE;
            ST_DONE: state_nxt = ST_IDLE;
            default: state_nxt = ST_IDLE;
        endcase
    end

    // Length of the phase being entered.
    always_comb begin
        case (state_nxt)
            ST_WSET: phase_len = CNT_W'(N_AS);
            ST_WPUL: phase_len = CNT_W'(N_WP);
            ST_WHLD: phase_len = CNT_W'(N_WH);
            ST_RACC: phase_len = CNT_W'(N_RD);
            default: phase_len = CNT_W'(1);
        endcase
    end

    assign phase_load = (state_nxt != state_q);

    asram_phase_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (phase_load),
        .len   (phase_len),
        .last  (phase_last)
    );

    // State register and pin pattern registered from the next state (glitch-free pins).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ctl_q   <= '0;
        end else begin
            state_q <= state_nxt;
            ctl_q   <= ctl_of(state_nxt);
        end
    end

    // Capture the request fields when it is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            be_q    <= '0;
            write_q <= 1'b0;
        end else if (accept) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            be_q    <= req_be;
            write_q <= req_write;
        end
    end

    // Read-to-write turnaround: clocks still owed to the memory's bus release.
    always_ff @(posedge clk) begin
        if (!rst_n)          ta_q <= '0;
        else if (rd_end)     ta_q <= TA_W'(N_TA);
        else if (ta_q != '0) ta_q <= ta_q - 1'b1;
    end

    // Sample the lane-masked read data in the last output-enable clock.
    always_ff @(posedge clk) begin
        if (!rst_n)      rdata_q <= '0;
        else if (rd_end) rdata_q <= rd_masked;
    end

    asram_lane_map u_lanes (
        .active    (ctl_q.sel),
        .be        (be_q),
        .rd_in     (mem_dq_i),
        .strobe_n  (strobe_n),
        .rd_masked (rd_masked)
    );

    if (HAS_CE2) begin : g_ce2
        assign mem_ce2 = ctl_q.sel;
    end else begin : g_no_ce2
        assign mem_ce2 = 1'b1;
    end

    assign mem_ce_n  = ~ctl_q.sel;
    assign mem_oe_n  = ~(ctl_q.oe & ~write_q);
    assign mem_we_n  = ~(ctl_q.we & write_q);
    assign mem_lb_n  = strobe_n[0];
    assign mem_ub_n  = strobe_n[1];
    assign mem_dq_oe = ctl_q.drive;
    assign mem_dq_o  = wdata_q;
    assign mem_addr  = addr_q;
    assign req_ready = ctl_q.done;
    assign rsp_rdata = rdata_q;

endmodule

// File: rtl/asram_ctrl_chk.sv
// Protocol checker for asram_ctrl, attached by bind. Observes only the
// memory-side pins and the ready pulse; window lengths use local counters.
module asram_ctrl_chk
    import asram_pkg::*;
#(
    parameter int ADDR_W  = 19,
    parameter int CLK_NS  = 10,
    parameter int T_WP_NS = 45,
    parameter int T_AW_NS = 45,
    parameter int T_DW_NS = 30,
    parameter int T_HZ_NS = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ce_n,
    input logic              mem_ce2,
    input logic              mem_oe_n,
    input logic              mem_we_n,
    input logic              mem_lb_n,
    input logic              mem_ub_n,
    input logic [15:0]       mem_dq_o,
    input logic              mem_dq_oe
);

    localparam int N_WP   = max3(ns_to_clk(T_WP_NS, CLK_NS),
                                 ns_to_clk(T_DW_NS, CLK_NS),
                                 ns_to_clk(T_AW_NS, CLK_NS));
    localparam int N_TA   = ns_to_clk(T_HZ_NS, CLK_NS);
    localparam int HZ_SAT = N_TA + 1;

    int we_len;
    int hz_cnt;

    // Length of the current write-enable low pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)         we_len <= 0;
        else if (!mem_we_n) we_len <= we_len + 1;
        else                we_len <= 0;
    end

    // Clocks since output enable was last low, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)              hz_cnt <= HZ_SAT;
        else if (!mem_oe_n)      hz_cnt <= 0;
        else if (hz_cnt < HZ_SAT) hz_cnt <= hz_cnt + 1;
    end

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_ce_n |-> (mem_we_n && mem_oe_n && mem_lb_n && mem_ub_n && !mem_dq_oe));

    p_oe_selected_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> (!mem_ce_n && mem_ce2 && mem_we_n && !mem_dq_oe));

    p_oe_after_select_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_oe_n) |-> $past(!mem_ce_n));

    p_we_selected_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (!mem_ce_n && mem_ce2 && mem_dq_oe && mem_oe_n));

    p_we_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (we_len == N_WP));

    p_we_data_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_we_n && $past(!mem_we_n)) |-> ($stable(mem_dq_o) && $stable(mem_addr)));

    p_turnaround_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_dq_oe) |-> (hz_cnt >= N_TA + 1));

    p_ready_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |=> !req_ready);

endmodule

bind asram_ctrl asram_ctrl_chk #(
    .ADDR_W  (ADDR_W),
    .CLK_NS  (CLK_NS),
    .T_WP_NS (T_WP_NS),
    .T_AW_NS (T_AW_NS),
    .T_DW_NS (T_DW_NS),
    .T_HZ_NS (T_HZ_NS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .mem_addr  (mem_addr),
    .mem_ce_n  (mem_ce_n),
    .mem_ce2   (mem_ce2),
    .mem_oe_n  (mem_oe_n),
    .mem_we_n  (mem_we_n),
    .mem_lb_n  (mem_lb_n),
    .mem_ub_n  (mem_ub_n),
    .mem_dq_o  (mem_dq_o),
    .mem_dq_oe (mem_dq_oe)
);

// File: tb/asram_ctrl_tb_top.sv
// Sweep bench: 16-word behavioural SRAM, every address and lane pattern.
module asram_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int AW  = 4;
    localparam int WRDS = 1 << AW;

    // Expected phase lengths from the nanosecond budgets (R2).
    function automatic int cdiv(int ns);
        int c;
        c = (ns + CLK_PERIOD - 1) / CLK_PERIOD;
        return (c < 1) ? 1 : c;
    endfunction
    function automatic int mx(int a, int b);
        return (a > b) ? a : b;
    endfunction

    localparam int NAS = cdiv(0);
    localparam int NWP = mx(mx(cdiv(45), cdiv(30)), cdiv(45));
    localparam int NWH = cdiv(0);
    localparam int NRD = mx(mx(cdiv(55), cdiv(55)), cdiv(30));
    localparam int NTA = cdiv(20);
    localparam int LAT_RD = 2 + NRD;
    localparam int LAT_WR = NAS + NWP + NWH + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0] req_be = '0;
    logic req_ready;
    logic [15:0] rsp_rdata;
    logic [AW-1:0] mem_addr;
    logic mem_ce_n, mem_ce2, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n;
    logic [15:0] mem_dq_o;
    logic mem_dq_oe;
    logic [15:0] mem_dq_i;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    asram_ctrl #(.ADDR_W(AW), .CLK_NS(CLK_PERIOD)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_be(req_be), .req_ready(req_ready),
        .rsp_rdata(rsp_rdata), .mem_addr(mem_addr), .mem_ce_n(mem_ce_n),
        .mem_ce2(mem_ce2), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n), .mem_dq_o(mem_dq_o),
        .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
    );

    // Behavioural memory.
    logic [15:0] mem_m [WRDS];
    logic [15:0] exp_m [WRDS];
    logic sel, rd_en;
    assign sel   = !mem_ce_n && mem_ce2;
    assign rd_en = sel && !mem_oe_n && mem_we_n;
    assign mem_dq_i[7:0]  = (rd_en && !mem_lb_n) ? mem_m[mem_addr][7:0]  : 8'h00;
    assign mem_dq_i[15:8] = (rd_en && !mem_ub_n) ? mem_m[mem_addr][15:8] : 8'h00;

    bit        wr_prev = 0;
    logic [15:0] wd_prev;
    logic [AW-1:0] wa_prev;
    logic      lb_prev, ub_prev;
    int oe_len = 0, last_oe = 0, we_len = 0, last_we = 0, hz = 100;
    logic [1:0] be_cur = '0;
    bit strobe_bad = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Pin monitor and write commit, sampled away from the active edge.
    always @(negedge clk) begin
        bit wr_now;
        wr_now = sel && !mem_we_n;
        if (wr_prev && !wr_now) begin
            if (!lb_prev) mem_m[wa_prev][7:0]  = wd_prev[7:0];
            if (!ub_prev) mem_m[wa_prev][15:8] = wd_prev[15:8];
        end
        if (wr_now) begin
            wd_prev = mem_dq_o; wa_prev = mem_addr; lb_prev = mem_lb_n; ub_prev = mem_ub_n;
        end
        wr_prev = wr_now;
        if (!mem_oe_n) oe_len++; else if (oe_len != 0) begin last_oe = oe_len; oe_len = 0; end
        if (!mem_we_n) we_len++; else if (we_len != 0) begin last_we = we_len; we_len = 0; end
        if (sel && (mem_lb_n != !be_cur[0] || mem_ub_n != !be_cur[1])) strobe_bad = 1;
        if (rd_en) hz = 0; else if (hz < 100) hz++;
        // R7: driver enable must come after the memory's release window.
        if (mem_dq_oe && (rd_en || (hz <= NTA + 1 && hz > 0 && wr_now == 0 && mem_we_n && !wr_prev && hz_first(hz))))
            check(0, "R7 turnaround", hz, NTA + 2);
    end

    bit dq_oe_prev = 0;
    function automatic bit hz_first(int h);
        return !dq_oe_prev && h >= 0;
    endfunction
    always @(negedge clk) begin
        #1 dq_oe_prev = mem_dq_oe;
    end

    int prev_kind = 0; // 0 idle, 1 read done, 2 write done

    task automatic xfer(input bit wr, input logic [AW-1:0] a, input logic [15:0] d,
                        input logic [1:0] be, output logic [15:0] rd, output int lat);
        be_cur = be; strobe_bad = 0;
        req_valid = 1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
        lat = 0; rd = '0;
        while (1) begin
            @(posedge clk); lat++;
            @(negedge clk);
            if (lat == 4) begin // R9: disturb inputs after acceptance
                req_addr = ~a; req_wdata = ~d; req_be = ~be; req_write = ~wr;
            end
            if (req_ready) begin rd = rsp_rdata; break; end
            if (lat > 60) break;
        end
        req_valid = 0;
        #1;
    endtask

    task automatic do_wr(input logic [AW-1:0] a, input logic [15:0] d, input logic [1:0] be);
        logic [15:0] rd; int lat, exp_lat;
        exp_lat = LAT_WR + ((prev_kind != 0) ? 1 : 0) + ((prev_kind == 1) ? NTA - 1 : 0);
        xfer(1, a, d, be, rd, lat);
        check(lat == exp_lat, "R8 write latency", lat, exp_lat);
        check(last_we == NWP, "R5 write pulse clocks", last_we, NWP);
        check(!strobe_bad, "R6 write strobes", {mem_ub_n, mem_lb_n}, ~be);
        if (be[0]) exp_m[a][7:0]  = d[7:0];
        if (be[1]) exp_m[a][15:8] = d[15:8];
        prev_kind = 2;
    endtask

    task automatic do_rd(input logic [AW-1:0] a, input logic [1:0] be);
        logic [15:0] rd, ex; int lat, exp_lat;
        exp_lat = LAT_RD + ((prev_kind != 0) ? 1 : 0);
        ex = exp_m[a] & {{8{be[1]}}, {8{be[0]}}};
        xfer(0, a, 16'h0, be, rd, lat);
        check(lat == exp_lat, "R8 read latency", lat, exp_lat);
        check(last_oe == NRD, "R3 output-enable clocks", last_oe, NRD);
        check(!strobe_bad, "R6 read strobes", 0, 0);
        check(rd == ex, "R4 read data", rd, ex);
        prev_kind = 1;
    endtask

    task automatic check_idle(input string tag);
        bit ok;
        ok = mem_ce_n && !mem_ce2 && mem_oe_n && mem_we_n && mem_lb_n && mem_ub_n
             && !mem_dq_oe && !req_ready;
        check(ok, tag, {mem_ce_n, mem_ce2, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n, mem_dq_oe, req_ready}, 8'b1011_1100);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
        check_idle("R1 idle pins");
        prev_kind = 0;
    endtask

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < WRDS; i++) begin mem_m[i] = 16'h0000; exp_m[i] = 16'h0000; end
        repeat (4) @(negedge clk);
        check_idle("R1 pins in reset");
        rst_n = 1;
        idle(3);
        // Full-word fill, back to back.
        for (int a = 0; a < WRDS; a++) do_wr(AW'(a), 16'hA55A ^ 16'(a * 16'h1357), 2'b11);
        for (int a = 0; a < WRDS; a++) do_rd(AW'(a), 2'b11);
        // Interleaved masked writes and reads: exercises turnaround (R7) and lanes (R6).
        for (int a = 0; a < WRDS; a++) begin
            do_wr(AW'(a), 16'h3CC3 + 16'(a * 16'h0F1E), 2'(a % 4));
            do_rd(AW'(a), 2'((a / 4) % 4));
            do_wr(AW'(WRDS - 1 - a), 16'hFFFF, 2'b00); // R6: no lane written
        end
        idle(4);
        for (int b = 0; b < 4; b++)
            for (int a = 0; a < WRDS; a++) do_rd(AW'(a), 2'(b));
        idle(3);
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule